// File: doc/BRIEF.md
# Legacy Platform Control Port Block

This block answers byte-wide I/O cycles aimed at a small set of legacy platform-control ports. Some ports return fixed status bytes. One port is a read/write control register. Two ports are scratch bytes. Two more ports flip the bits of a two-bit password lock on every write, whatever the data.

Writes to certain ports do not store anything. Instead they raise event requests: a soft-reset request, a little-endian mode request and a non-contiguous I/O-map request. Each request is a registered pulse one clock long, and whatever consumes the pulse acts on it elsewhere.

The bus side has one address, a read strobe, a write strobe, a write byte and a read byte. Read data is combinational and valid in the same cycle as the read strobe. A write takes effect at the clock edge that samples it. When a read and a write land in the same cycle, the read returns the value held before the write.

Top module: `legacy_sysctl_ports`

## Requirements
- R1: After reset the system-control register, both lock bits and both scratch bytes are zero, and all three event outputs are low.
- R2: Reads of the fixed ports return constants: 0x092 gives 0x40, 0x80C gives 0xFC, 0x818 gives 0x00, 0x823 gives 0x03, and 0x850 gives 0x00. A write to 0x092 stores nothing, so 0x092 still reads 0x40 afterwards.
- R3: Port 0x81C returns the last byte written to it, and it changes only when written.
- R4: Any write to 0x810 inverts `nvram_lock[0]`, and any write to 0x812 inverts `nvram_lock[1]`. The write data has no effect on either.
- R5: A write to 0x092 with data bit 7 set makes `soft_reset_req` high for exactly the one cycle after the write. Otherwise the output stays low.
- R6: A write to 0x092 with data bit 6 set makes `le_mode_req` high for exactly the one cycle after the write. Otherwise the output stays low.
- R7: A write to 0x850 with data bit 7 set makes `iomap_err` high for exactly the one cycle after the write. Otherwise the output stays low.
- R8: A read of any address not listed in R2, R3 or R9 returns 0xFF. This includes 0x808, 0x810, 0x812 and 0x814, and any address whose upper bits differ from a listed port. Writes to such addresses change no register, no lock bit and no event output.
- R9: Ports 0x398 and 0x399 are two independent scratch bytes. Each one reads back the last byte written to it.
- R10: While `io_rd` is low, `io_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 16 | I/O port address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, valid while io_rd is high |
| nvram_lock | output | 2 | Password-lock state bits |
| soft_reset_req | output | 1 | One-cycle soft-reset request |
| le_mode_req | output | 1 | One-cycle little-endian mode request |
| iomap_err | output | 1 | One-cycle non-contiguous I/O-map request |

## Verification
The hardest thing to catch is a write that lands somewhere it should not. That would be an alias in the decode, where a wide address or a neighbouring discard port quietly updates the control register, a scratch byte or a lock bit, or fires an event. To expose this, the bench writes a data byte derived from the address to every address in an 8K window. After each write it checks all three event outputs and the lock bits against its own model. It then sweeps reads over the whole window and compares every byte with the expected map. The two event ports are also driven with all 256 data values, which covers every combination of the trigger bits.

// File: rtl/legacy_sysctl_pkg.sv
package legacy_sysctl_pkg;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_EVT,
        SEL_EQUIP,
        SEL_KEYLOCK,
        SEL_CTRL,
        SEL_CACHE,
        SEL_MAP,
        SEL_LOCK0,
        SEL_LOCK1,
        SEL_SCR,
        SEL_DISCARD
    } port_sel_e;

    localparam logic [7:0] EVT_RD_VAL   = 8'h40;
    localparam logic [7:0] EQUIP_RD_VAL = 8'hFC;
    localparam logic [7:0] KEY_RD_VAL   = 8'h00;
    localparam logic [7:0] CACHE_RD_VAL = 8'h03;
    localparam logic [7:0] MAP_RD_VAL   = 8'h00;
    localparam logic [7:0] OPEN_RD_VAL  = 8'hFF;

endpackage

// File: rtl/legacy_sysctl_decode.sv
module legacy_sysctl_decode
    import legacy_sysctl_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int SCR_N    = 2,
    parameter int SCR_BASE = 'h398,
    localparam int IDX_W   = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output port_sel_e         sel,
    output logic [IDX_W-1:0]  scr_idx
);

    always_comb begin
        sel     = SEL_NONE;
        scr_idx = '0;
        case (addr)
            ADDR_W'('h092): sel = SEL_EVT;
            ADDR_W'('h80C): sel = SEL_EQUIP;
            ADDR_W'('h818): sel = SEL_KEYLOCK;
            ADDR_W'('h81C): sel = SEL_CTRL;
            ADDR_W'('h823): sel = SEL_CACHE;
            ADDR_W'('h850): sel = SEL_MAP;
            ADDR_W'('h810): sel = SEL_LOCK0;
            ADDR_W'('h812): sel = SEL_LOCK1;
            ADDR_W'('h808),
            ADDR_W'('h814): sel = SEL_DISCARD;
            default:        sel = SEL_NONE;
        endcase
        for (int i = 0; i < SCR_N; i++) begin
            if (addr == ADDR_W'(SCR_BASE + i)) begin
                sel     = SEL_SCR;
                scr_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/legacy_sysctl_regs.sv
module legacy_sysctl_regs
    import legacy_sysctl_pkg::*;
#(
    parameter int SCR_N  = 2,
    localparam int IDX_W = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  port_sel_e             sel,
    input  logic [IDX_W-1:0]      scr_idx,
    input  logic [7:0]            wdata,
    output logic [7:0]            ctrl,
    output logic [1:0]            lock,
    output logic [SCR_N-1:0][7:0] scr,
    output logic                  evt_reset,
    output logic                  evt_le,
    output logic                  evt_map
);

    typedef struct packed {
        logic [7:0]            ctrl;
        logic [1:0]            lock;
        logic [SCR_N-1:0][7:0] scr;
        logic                  evt_reset;
        logic                  evt_le;
        logic                  evt_map;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.evt_reset = 1'b0;
        st_d.evt_le    = 1'b0;
        st_d.evt_map   = 1'b0;
        if (wr_en) begin
            case (sel)
                SEL_EVT: begin
                    st_d.evt_reset = wdata[7];
                    st_d.evt_le    = wdata[6];
                end
                SEL_MAP:   st_d.evt_map     = wdata[7];
                SEL_CTRL:  st_d.ctrl        = wdata;
                SEL_LOCK0: st_d.lock[0]     = ~st_q.lock[0];
                SEL_LOCK1: st_d.lock[1]     = ~st_q.lock[1];
                SEL_SCR:   st_d.scr[scr_idx] = wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ctrl      = st_q.ctrl;
    assign lock      = st_q.lock;
    assign scr       = st_q.scr;
    assign evt_reset = st_q.evt_reset;
    assign evt_le    = st_q.evt_le;
    assign evt_map   = st_q.evt_map;

    assert_reset_evt_src_R5: assert property (@(posedge clk) disable iff (rst)
        evt_reset |-> $past(wr_en && sel == SEL_EVT && wdata[7]));

    assert_le_evt_src_R6: assert property (@(posedge clk) disable iff (rst)
        evt_le |-> $past(wr_en && sel == SEL_EVT && wdata[6]));

    assert_map_evt_src_R7: assert property (@(posedge clk) disable iff (rst)
        evt_map |-> $past(wr_en && sel == SEL_MAP && wdata[7]));

    assert_lock0_flip_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en && sel == SEL_LOCK0)) |-> (lock[0] != $past(lock[0])));

    assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en && sel == SEL_CTRL)) |-> $stable(ctrl));

    assert_scr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en && sel == SEL_SCR)) |-> $stable(scr));

endmodule

// File: rtl/legacy_sysctl_rdmux.sv
module legacy_sysctl_rdmux
    import legacy_sysctl_pkg::*;
#(
    parameter int SCR_N  = 2,
    localparam int IDX_W = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
    input  logic                  rd_en,
    input  port_sel_e             sel,
    input  logic [IDX_W-1:0]      scr_idx,
    input  logic [7:0]            ctrl,
    input  logic [SCR_N-1:0][7:0] scr,
    output logic [7:0]            rdata
);

    always_comb begin
        rdata = 8'h00;
        if (rd_en) begin
            case (sel)
                SEL_EVT:     rdata = EVT_RD_VAL;
                SEL_EQUIP:   rdata = EQUIP_RD_VAL;
                SEL_KEYLOCK: rdata = KEY_RD_VAL;
                SEL_CTRL:    rdata = ctrl;
                SEL_CACHE:   rdata = CACHE_RD_VAL;
                SEL_MAP:     rdata = MAP_RD_VAL;
                SEL_SCR:     rdata = scr[scr_idx];
                default:     rdata = OPEN_RD_VAL;
            endcase
        end
    end

endmodule

// File: rtl/legacy_sysctl_ports.sv
module legacy_sysctl_ports
    import legacy_sysctl_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int SCR_N    = 2,
    parameter int SCR_BASE = 'h398
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic [1:0]        nvram_lock,
    output logic              soft_reset_req,
    output logic              le_mode_req,
    output logic              iomap_err
);

    localparam int IDX_W = (SCR_N > 1) ? $clog2(SCR_N) : 1;

    port_sel_e             sel;
    logic [IDX_W-1:0]      scr_idx;
    logic [7:0]            ctrl;
    logic [SCR_N-1:0][7:0] scr;

    legacy_sysctl_decode #(.ADDR_W(ADDR_W), .SCR_N(SCR_N), .SCR_BASE(SCR_BASE)) u_decode (
        .addr    (io_addr),
        .sel     (sel),
        .scr_idx (scr_idx)
    );

    legacy_sysctl_regs #(.SCR_N(SCR_N)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (io_wr),
        .sel       (sel),
        .scr_idx   (scr_idx),
        .wdata     (io_wdata),
        .ctrl      (ctrl),
        .lock      (nvram_lock),
        .scr       (scr),
        .evt_reset (soft_reset_req),
        .evt_le    (le_mode_req),
        .evt_map   (iomap_err)
    );

    legacy_sysctl_rdmux #(.SCR_N(SCR_N)) u_rdmux (
        .rd_en   (io_rd),
        .sel     (sel),
        .scr_idx (scr_idx),
        .ctrl    (ctrl),
        .scr     (scr),
        .rdata   (io_rdata)
    );

    assert_evt_port_const_R2: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr == ADDR_W'('h092)) |-> (io_rdata == 8'h40));

    assert_discard_reads_open_R8: assert property (@(posedge clk) disable iff (rst)
        (io_rd && (io_addr == ADDR_W'('h808) || io_addr == ADDR_W'('h814))) |-> (io_rdata == 8'hFF));

    assert_idle_bus_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (!io_rd) |-> (io_rdata == 8'h00));

    assert_lock_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(io_wr)) |-> $stable(nvram_lock));

endmodule

// File: tb/legacy_sysctl_ports_tb.sv
module legacy_sysctl_ports_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [1:0]  nvram_lock;
    logic        soft_reset_req, le_mode_req, iomap_err;

    int checks = 0;
    int failures = 0;

    logic [7:0] m_ctrl = 8'h00;
    logic [1:0] m_lock = 2'b00;
    logic [7:0] m_scr0 = 8'h00;
    logic [7:0] m_scr1 = 8'h00;
    logic       e_rst, e_le, e_map;

    always #2 clk = ~clk;

    legacy_sysctl_ports u_dut (
        .clk            (clk),
        .rst            (rst),
        .io_addr        (io_addr),
        .io_rd          (io_rd),
        .io_wr          (io_wr),
        .io_wdata       (io_wdata),
        .io_rdata       (io_rdata),
        .nvram_lock     (nvram_lock),
        .soft_reset_req (soft_reset_req),
        .le_mode_req    (le_mode_req),
        .iomap_err      (iomap_err)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input int a);
        case (a)
            'h092:   return 8'h40;
            'h80C:   return 8'hFC;
            'h818:   return 8'h00;
            'h81C:   return m_ctrl;
            'h823:   return 8'h03;
            'h850:   return 8'h00;
            'h398:   return m_scr0;
            'h399:   return m_scr1;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic string req_of(input int a);
        case (a)
            'h092, 'h80C, 'h818, 'h823, 'h850: return "R2";
            'h81C:                             return "R3";
            'h398, 'h399:                      return "R9";
            default:                           return "R8";
        endcase
    endfunction

    task automatic do_read(input int a);
        @(negedge clk);
        io_wr   = 1'b0;
        io_rd   = 1'b1;
        io_addr = 16'(a);
        #1;
        chk(req_of(a), io_rdata, exp_rd(a));
    endtask

    task automatic do_write(input int a, input logic [7:0] d);
        @(negedge clk);
        io_rd    = 1'b0;
        io_wr    = 1'b1;
        io_addr  = 16'(a);
        io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
        e_rst = 1'b0;
        e_le  = 1'b0;
        e_map = 1'b0;
        case (a)
            'h092: begin e_rst = d[7]; e_le = d[6]; end
            'h850: e_map = d[7];
            'h81C: m_ctrl = d;
            'h810: m_lock[0] = ~m_lock[0];
            'h812: m_lock[1] = ~m_lock[1];
            'h398: m_scr0 = d;
            'h399: m_scr1 = d;
            default: ;
        endcase
        #1;
        chk("R5", {7'd0, soft_reset_req}, {7'd0, e_rst});
        chk("R6", {7'd0, le_mode_req}, {7'd0, e_le});
        chk("R7", {7'd0, iomap_err}, {7'd0, e_map});
        chk("R4", {6'd0, nvram_lock}, {6'd0, m_lock});
        chk("R10", io_rdata, 8'h00);
    endtask

    task automatic idle_check();
        @(negedge clk);
        io_rd = 1'b0;
        io_wr = 1'b0;
        #1;
        chk("R5", {7'd0, soft_reset_req}, 8'h00);
        chk("R6", {7'd0, le_mode_req}, 8'h00);
        chk("R7", {7'd0, iomap_err}, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1", {6'd0, nvram_lock}, 8'h00);
        chk("R1", {5'd0, soft_reset_req, le_mode_req, iomap_err}, 8'h00);
        do_read('h81C);
        chk("R1", io_rdata, 8'h00);
        do_read('h398);
        chk("R1", io_rdata, 8'h00);
        do_read('h399);
        chk("R1", io_rdata, 8'h00);

        // read sweep over the reset map
        for (int a = 0; a < 'h2000; a++) do_read(a);

        // write every address, then read the whole window back
        for (int a = 0; a < 'h2000; a++) do_write(a, 8'(a) ^ 8'hC3);
        for (int a = 0; a < 'h2000; a++) do_read(a);

        // aliased high addresses read open (R8)
        do_read('h8092);
        do_read('hF81C);
        do_read('h4398);

        // all data values on the event ports; lock writes ignore data
        for (int d = 0; d < 256; d++) begin
            do_write('h092, 8'(d));
            do_write('h850, 8'(d));
            if (d % 17 == 0) do_write('h810, 8'(d));
            if (d % 23 == 0) do_write('h812, 8'(d));
        end

        // one-cycle pulse width
        do_write('h092, 8'hC0);
        idle_check();
        do_write('h850, 8'h80);
        idle_check();

        // independent scratch bytes and control readback
        do_write('h398, 8'h5A);
        do_write('h399, 8'hA5);
        do_read('h398);
        do_read('h399);
        do_write('h81C, 8'h3C);
        do_read('h81C);
        do_write('h092, 8'hFF);
        do_read('h092);

        // discard ports keep state
        do_write('h808, 8'h11);
        do_write('h814, 8'h22);
        do_read('h81C);
        do_read('h398);
        do_read('h399);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule